// File: doc/BRIEF.md
# March Algorithm Memory Self-Test Controller

This block is a built-in self-test sequencer for a word-addressed single-port RAM. After a start pulse it works through a short table of march elements. Each element has an address direction and a list of one or two operations. An operation writes or reads an all-zeros or all-ones word. The element applies its whole operation list to one word and then moves on to the next address. The element table is chosen by a two-bit algorithm select. The choices are a four-pass scan test, a five-operations-per-word test and a ten-operations-per-word test.

Every read is compared with its expected word one cycle after the request, which matches the RAM's read latency. The first mismatch is recorded: its address, the element index and the position of the operation inside the element. An optional retention pause, counted in clock cycles, can be placed in front of every element that begins with a read. Cells then hold each state for a chosen time before they are checked. The controller can either finish the whole algorithm after a failure or stop at the first one.

Top module: `mbist_march`

## Requirements
- R1: After reset, and whenever no test runs, busy_o, done_o, fail_o and mem_req_o are low.
- R2: Each element visits every address exactly once and applies all of its operations to an address before moving to the next one. Ascending elements go from 0 up to 2^ADDR_W-1. Descending elements go through the exact reverse of that sequence.
- R3: algo_i = 0 selects the scan test, with four ascending elements: write 0, read 0, write 1, read 1.
- R4: algo_i = 1 selects the 5n test: write 0 ascending; then (read 0, write 1) ascending; then (read 1, write 0) descending.
- R5: algo_i = 2 selects the 10n test: write 0; (r0,w1) ascending; (r1,w0) ascending; (r0,w1) descending; (r1,w0) descending; read 0 ascending. algo_i = 3 runs the same sequence.
- R6: Write data is the written bit copied across all DATA_W bits. A read is checked against the expected bit copied across the word, using mem_rdata_i in the cycle after the read request.
- R7: If retention is enabled and ret_dly_i = P > 0, then in front of each element whose first operation is a read there are exactly P cycles with mem_req_o low. If P = 0 or retention is disabled, there is no pause.
- R8: The first mismatch raises fail_o and latches fail_addr_o, fail_elem_o (element index from 0, in algorithm order) and fail_op_o (0 for the first operation in the element, 1 for the second). Later mismatches do not change these values.
- R9: With stop_on_fail_i low, the whole algorithm runs even after a failure. With it high, exactly one more operation is issued after the failing read, and done_o rises on the edge where the mismatch is seen.
- R10: done_o stays high until the next start. A start while busy is ignored. A new start clears fail_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a test when idle or done |
| algo_i | input | 2 | Algorithm select, captured at start |
| ret_en_i | input | 1 | Enables retention pauses |
| ret_dly_i | input | DLY_W | Pause length in cycles |
| stop_on_fail_i | input | 1 | Stop at the first mismatch |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished |
| fail_o | output | 1 | At least one mismatch |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_elem_o | output | 3 | Element index of the first mismatch |
| fail_op_o | output | 1 | Operation index of the first mismatch |
| mem_req_o | output | 1 | RAM access request |
| mem_we_o | output | 1 | Write enable (read when low) |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after the request |

## Verification
The bench builds the controller with ADDR_W = 3, DATA_W = 4 and DLY_W = 8. With these values there are eight words, so every full element, both address ends and the reversed descending order are covered in full scoreboard runs of at most 80 operations. The four-bit word with a stuck bit at a chosen address shows that the compare uses the full width. Short pauses of 3 and 5 cycles make it possible to count the retention gaps exactly.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int unsigned ELEM_W = 3;

  typedef enum logic [1:0] {
    ALG_SCAN4 = 2'd0,
    ALG_5N    = 2'd1,
    ALG_10N   = 2'd2,
    ALG_10N_B = 2'd3
  } algo_e;

  typedef struct packed {
    logic wr;
    logic val;
  } mop_t;

  typedef struct packed {
    logic desc;
    logic two;
    mop_t op0;
    mop_t op1;
  } melem_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_PAUSE, ST_DRAIN, ST_DONE
  } mstate_e;
endpackage

// File: rtl/mbist_elem_rom.sv
module mbist_elem_rom import mbist_pkg::*; (
  input  logic [1:0]        algo_i,
  input  logic [ELEM_W-1:0] idx_i,
  output melem_t            cur_o,
  output logic              cur_last_o,
  output logic              nxt_pause_o
);
  function automatic melem_t mk(logic d, logic t, logic w0, logic v0, logic w1, logic v1);
    melem_t e;
    e.desc = d; e.two = t;
    e.op0.wr = w0; e.op0.val = v0;
    e.op1.wr = w1; e.op1.val = v1;
    return e;
  endfunction

  function automatic melem_t lookup(logic [1:0] a, logic [ELEM_W-1:0] i);
    melem_t e;
    e = mk(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    case (algo_e'(a))
      ALG_SCAN4: case (i)
        3'd1:    e = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        3'd2:    e = mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        3'd3:    e = mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        default: ;
      endcase
      ALG_5N: case (i)
        3'd1:    e = mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        3'd2:    e = mk(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        default: ;
      endcase
      default: case (i)
        3'd1:    e = mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        3'd2:    e = mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        3'd3:    e = mk(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        3'd4:    e = mk(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        3'd5:    e = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        default: ;
      endcase
    endcase
    return e;
  endfunction

  function automatic logic [ELEM_W-1:0] last_idx(logic [1:0] a);
    case (algo_e'(a))
      ALG_SCAN4: return 3'd3;
      ALG_5N:    return 3'd2;
      default:   return 3'd5;
    endcase
  endfunction

  function automatic logic read_first(logic [1:0] a, logic [ELEM_W-1:0] i);
    melem_t e;
    e = lookup(a, i);
    return !e.op0.wr;
  endfunction

  assign cur_o       = lookup(algo_i, idx_i);
  assign cur_last_o  = (idx_i == last_idx(algo_i));
  assign nxt_pause_o = read_first(algo_i, idx_i + 1'b1);
endmodule

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              desc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (step_i) idx_q <= idx_q + 1'b1;
  end

  // descending order is the bitwise mirror of the ascending one
  assign addr_o = desc_i ? ~idx_q : idx_q;
  assign last_o = &idx_q;

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i && !last_o |=> (desc_i ? (addr_o == $past(addr_o) - 1'b1)
                                            : (addr_o == $past(addr_o) + 1'b1)));
endmodule

// File: rtl/mbist_resp_chk.sv
module mbist_resp_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ELEM_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic              exp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic              op_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mism_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic              fail_op_o
);
  logic              pend_q, exp_q, op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ELEM_W-1:0] elem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0; exp_q <= 1'b0; op_q <= 1'b0;
      addr_q <= '0;   elem_q <= '0;
    end else begin
      pend_q <= rd_i && !clr_i;
      if (rd_i) begin
        exp_q <= exp_i; op_q <= op_i; addr_q <= addr_i; elem_q <= elem_i;
      end
    end
  end

  assign mism_o = pend_q && (rdata_i != {DATA_W{exp_q}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o <= 1'b0; fail_addr_o <= '0; fail_elem_o <= '0; fail_op_o <= 1'b0;
    end else if (clr_i) begin
      fail_o <= 1'b0; fail_addr_o <= '0; fail_elem_o <= '0; fail_op_o <= 1'b0;
    end else if (mism_o && !fail_o) begin
      fail_o <= 1'b1; fail_addr_o <= addr_q; fail_elem_o <= elem_q; fail_op_o <= op_q;
    end
  end

  assert_fail_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clr_i |=> fail_o && (fail_addr_o == $past(fail_addr_o))
                         && (fail_elem_o == $past(fail_elem_o)));
  assert_fail_from_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(pend_q));
endmodule

// File: rtl/mbist_march.sv
module mbist_march import mbist_pkg::*; #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DLY_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        algo_i,
  input  logic              ret_en_i,
  input  logic [DLY_W-1:0]  ret_dly_i,
  input  logic              stop_on_fail_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic              fail_op_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  mstate_e           state_q;
  logic [ELEM_W-1:0] elem_q;
  logic              op_q, ret_en_q, stop_q;
  logic [1:0]        algo_q;
  logic [DLY_W-1:0]  dly_q, cnt_q;

  melem_t cur;
  mop_t   op;
  logic   cur_last, nxt_pause, addr_last, op_last;
  logic   launch, run, step, addr_clr, mism, halt;

  mbist_elem_rom i_rom (
    .algo_i(algo_q), .idx_i(elem_q),
    .cur_o(cur), .cur_last_o(cur_last), .nxt_pause_o(nxt_pause)
  );

  assign launch   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign run      = (state_q == ST_RUN);
  assign op       = op_q ? cur.op1 : cur.op0;
  assign op_last  = !cur.two || op_q;
  assign step     = run && op_last && !addr_last;
  assign addr_clr = launch || (run && op_last && addr_last);
  assign halt     = mism && stop_q && busy_o;

  mbist_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i, .rst_ni, .clr_i(addr_clr), .step_i(step), .desc_i(cur.desc),
    .addr_o(mem_addr_o), .last_o(addr_last)
  );

  mbist_resp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ELEM_W(ELEM_W)) i_chk (
    .clk_i, .rst_ni, .clr_i(launch), .rd_i(run && !op.wr), .exp_i(op.val),
    .addr_i(mem_addr_o), .elem_i(elem_q), .op_i(op_q), .rdata_i(mem_rdata_i),
    .mism_o(mism), .fail_o, .fail_addr_o, .fail_elem_o, .fail_op_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; elem_q <= '0; op_q <= 1'b0; algo_q <= '0;
      ret_en_q <= 1'b0; stop_q <= 1'b0; dly_q <= '0; cnt_q <= '0;
    end else if (launch) begin
      state_q <= ST_RUN; elem_q <= '0; op_q <= 1'b0; algo_q <= algo_i;
      ret_en_q <= ret_en_i; stop_q <= stop_on_fail_i; dly_q <= ret_dly_i;
    end else if (halt) begin
      state_q <= ST_DONE;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (!op_last) op_q <= 1'b1;
          else begin
            op_q <= 1'b0;
            if (addr_last) begin
              if (cur_last) state_q <= ST_DRAIN;
              else begin
                elem_q <= elem_q + 1'b1;
                if (ret_en_q && nxt_pause && dly_q != '0) begin
                  state_q <= ST_PAUSE;
                  cnt_q   <= dly_q;
                end
              end
            end
          end
        end
        ST_PAUSE: begin
          if (cnt_q <= 1) state_q <= ST_RUN;
          else            cnt_q   <= cnt_q - 1'b1;
        end
        ST_DRAIN: state_q <= ST_DONE;
        default:  ;
      endcase
    end
  end

  assign busy_o      = (state_q == ST_RUN) || (state_q == ST_PAUSE) || (state_q == ST_DRAIN);
  assign done_o      = (state_q == ST_DONE);
  assign mem_req_o   = run;
  assign mem_we_o    = run && op.wr;
  assign mem_wdata_o = {DATA_W{op.val}};

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  assert_launch_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> busy_o && !fail_o);
  assert_pause_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PAUSE |-> cnt_q != '0);
  assert_done_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == ST_DRAIN) || $past(mism && stop_q));
endmodule

// File: tb/test_mbist_march.sv
module test_mbist_march;
  localparam int AW = 3;
  localparam int DW = 4;
  localparam int LW = 8;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ret_en = 1'b0, stop = 1'b0;
  logic [1:0] algo = '0;
  logic [LW-1:0] dly = '0;
  logic busy, done, fail, fop, req, we;
  logic [AW-1:0] faddr, addr;
  logic [2:0] felem;
  logic [DW-1:0] wdata, rdata;

  always #5 clk = ~clk;

  mbist_march #(.ADDR_W(AW), .DATA_W(DW), .DLY_W(LW)) i_mbist_march (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .algo_i(algo),
    .ret_en_i(ret_en), .ret_dly_i(dly), .stop_on_fail_i(stop),
    .busy_o(busy), .done_o(done), .fail_o(fail), .fail_addr_o(faddr),
    .fail_elem_o(felem), .fail_op_o(fop), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  // RAM model: one-cycle read latency, optional stuck bit 0 at one address
  logic [DW-1:0] mem [NW];
  int fault_kind = 0;  // 0 none, 1 stuck-at-0, 2 stuck-at-1
  logic [AW-1:0] fault_addr = '0;
  initial for (int i = 0; i < NW; i++) mem[i] = '0;
  always @(posedge clk) if (req) begin
    if (we) mem[addr] <= wdata;
    else if (fault_kind == 1 && addr == fault_addr) rdata <= mem[addr] & ~DW'(1);
    else if (fault_kind == 2 && addr == fault_addr) rdata <= mem[addr] | DW'(1);
    else rdata <= mem[addr];
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard: {we, addr, data}
  typedef struct packed { logic w; logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t exp_q[$];
  bit mon_en = 1'b1;
  int op_cnt = 0, gap = 0;
  int gaps[$];

  always @(negedge clk) begin
    if (busy && !req) gap++;
    if (req) begin
      op_cnt++;
      if (gap > 0) gaps.push_back(gap);
      gap = 0;
      if (mon_en) begin
        if (exp_q.size() == 0) chk(1'b0, "R2,R6 extra op", int'(addr), -1);
        else begin
          item_t e;
          e = exp_q.pop_front();
          chk(we == e.w && addr == e.a && wdata == e.d, "R2,R6 op order/data",
              int'({we, addr, wdata}), int'(e));
        end
      end
    end
  end

  task automatic push_elem(input bit desc, input bit two,
                           input bit w0, input bit v0, input bit w1, input bit v1);
    for (int i = 0; i < NW; i++) begin
      logic [AW-1:0] a;
      a = desc ? AW'(NW - 1 - i) : AW'(i);
      exp_q.push_back({w0, a, {DW{v0}}});
      if (two) exp_q.push_back({w1, a, {DW{v1}}});
    end
  endtask

  task automatic build(input int alg);
    exp_q.delete();
    case (alg)
      0: begin  // R3
        push_elem(0, 0, 1, 0, 0, 0); push_elem(0, 0, 0, 0, 0, 0);
        push_elem(0, 0, 1, 1, 0, 0); push_elem(0, 0, 0, 1, 0, 0);
      end
      1: begin  // R4
        push_elem(0, 0, 1, 0, 0, 0); push_elem(0, 1, 0, 0, 1, 1);
        push_elem(1, 1, 0, 1, 1, 0);
      end
      default: begin  // R5
        push_elem(0, 0, 1, 0, 0, 0); push_elem(0, 1, 0, 0, 1, 1);
        push_elem(0, 1, 0, 1, 1, 0); push_elem(1, 1, 0, 0, 1, 1);
        push_elem(1, 1, 0, 1, 1, 0); push_elem(0, 0, 0, 0, 0, 0);
      end
    endcase
  endtask

  task automatic launch(input int alg, input bit ren, input int p, input bit sof);
    @(negedge clk);
    algo = 2'(alg); ret_en = ren; dly = LW'(p); stop = sof;
    gaps.delete(); gap = 0; op_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done, {tag, " watchdog"}, int'(done), 1);
  endtask

  task automatic run_clean(input int alg, input string tag);
    build(alg); fault_kind = 0;
    launch(alg, 0, 0, 0);
    wait_done(tag);
    chk(exp_q.size() == 0, {tag, " all ops issued"}, exp_q.size(), 0);
    chk(!fail, {tag, " no fail"}, int'(fail), 0);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "global watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(!done, "R1 done", int'(done), 0);
    chk(!fail, "R1 fail", int'(fail), 0);
    chk(!req,  "R1 req",  int'(req), 0);

    run_clean(0, "R3 scan");
    repeat (3) @(negedge clk);
    chk(done && !busy && !req, "R10 done held", int'(done), 1);
    run_clean(1, "R4 5n");
    run_clean(2, "R5 10n");
    run_clean(3, "R5 10n alt code");

    // R7 retention
    build(0); launch(0, 1, 5, 0); wait_done("R7 scan");
    chk(gaps.size() == 2, "R7 scan pause count", gaps.size(), 2);
    foreach (gaps[i]) chk(gaps[i] == 5, "R7 scan pause length", gaps[i], 5);
    build(2); launch(2, 1, 3, 0); wait_done("R7 10n");
    chk(gaps.size() == 5, "R7 10n pause count", gaps.size(), 5);
    foreach (gaps[i]) chk(gaps[i] == 3, "R7 10n pause length", gaps[i], 3);
    build(1); launch(1, 1, 0, 0); wait_done("R7 zero");
    chk(gaps.size() == 0, "R7 zero delay no pause", gaps.size(), 0);
    build(1); launch(1, 0, 7, 0); wait_done("R7 disabled");
    chk(gaps.size() == 0, "R7 disabled no pause", gaps.size(), 0);

    // R8/R9 fault, run to end
    build(1); fault_kind = 2; fault_addr = 3'd5;
    launch(1, 0, 0, 0); wait_done("R8 5n sa1");
    chk(fail, "R8 fail raised", int'(fail), 1);
    chk(faddr == 3'd5 && felem == 3'd1 && fop == 1'b0, "R8 first fail info",
        int'({faddr, felem, fop}), int'({3'd5, 3'd1, 1'b0}));
    chk(exp_q.size() == 0, "R9 ran to completion", exp_q.size(), 0);

    // R2 descending detection
    build(1); fault_kind = 1; fault_addr = 3'd3;
    launch(1, 0, 0, 0); wait_done("R2 5n sa0");
    chk(fail && faddr == 3'd3 && felem == 3'd2 && fop == 1'b0, "R2 desc fail info",
        int'({faddr, felem, fop}), int'({3'd3, 3'd2, 1'b0}));

    build(0); fault_kind = 1; fault_addr = 3'd6;
    launch(0, 0, 0, 0); wait_done("R3 scan sa0");
    chk(fail && faddr == 3'd6 && felem == 3'd3 && fop == 1'b0, "R3 scan fail info",
        int'({faddr, felem, fop}), int'({3'd6, 3'd3, 1'b0}));

    // R8 later mismatches do not overwrite
    build(2); fault_kind = 2; fault_addr = 3'd5;
    launch(2, 0, 0, 0); wait_done("R8 10n sa1");
    chk(fail && faddr == 3'd5 && felem == 3'd1 && fop == 1'b0, "R8 sticky first",
        int'({faddr, felem, fop}), int'({3'd5, 3'd1, 1'b0}));

    // R10 new start clears fail
    run_clean(1, "R10 clear fail");

    // R9 stop on fail
    mon_en = 1'b0; fault_kind = 2; fault_addr = 3'd0;
    launch(2, 0, 0, 1); wait_done("R9 stop");
    chk(op_cnt == NW + 2, "R9 ops after stop", op_cnt, NW + 2);
    chk(fail && faddr == 3'd0 && felem == 3'd1, "R9 stop fail info",
        int'({faddr, felem}), int'({3'd0, 3'd1}));
    mon_en = 1'b1;

    // R10 start while busy ignored
    build(0); fault_kind = 0;
    launch(0, 0, 0, 0);
    repeat (5) @(negedge clk);
    algo = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10 busy start");
    chk(exp_q.size() == 0, "R10 start while busy ignored", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule